// File: doc/BRIEF.md
# Two-Thread Capped Dispatch Scheduler

This block is the small waiting buffer between the per-thread ready queues of one micro-op class and a single execution unit. The two threads each present micro-ops on their own valid/ready input stream. Every micro-op carries a thread id, a destination tag and two source tags, each with a ready bit. The block admits at most one micro-op per cycle. Admission alternates between the threads, and it is limited by a per-thread cap on live entries. Entries then wait until both sources are ready. Dispatch does not look at the thread id: the oldest ready entry from either thread is offered on a valid/ready output stream.

Completed results are announced on a tag broadcast bus. Any waiting source whose tag matches the broadcast becomes ready. A micro-op whose source matches the broadcast in the cycle it arrives also enters with that source ready. Memory and general micro-ops each use their own instance of this block.

Back-pressure rules: an input stream holds its micro-op stable while valid is high and ready is low. The block raises `in_ready` for at most one thread per cycle, and only for a thread whose valid is high. On the output, `dq_valid` stays high until `dq_ready` takes the offer. The offered entry may change while stalled, but only to an older entry that has just become ready.

Top module: `smt_sched`

## Requirements
- R1: After reset the buffer is empty, `dq_valid` is low, and thread 0 has admission priority.
- R2: When both threads can insert, admission goes to the thread other than the one admitted last, so the threads alternate cycle by cycle.
- R3: If the preferred thread has no valid micro-op or is at its cap, the other thread is admitted in that cycle if it can insert.
- R4: A thread holding CAP live entries (default 5) sees `in_ready` low for that thread.
- R5: When all DEPTH entries (default 8) are occupied, `in_ready` is low for both threads, even for a thread below its cap.
- R6: A broadcast with `wb_valid` high marks every waiting source whose tag equals `wb_tag` as ready. The entry can dispatch from the next cycle.
- R7: A source of an arriving micro-op whose tag equals the same cycle's broadcast is stored as ready.
- R8: An entry is offered on the dispatch port only when both of its sources are ready, whatever its thread.
- R9: Among ready entries, the one admitted earliest is offered, with age kept across both threads. `dq_tid` is 0 or 1 for the owning thread.
- R10: A dispatch frees the entry and lowers its thread's live count at the same clock edge. A thread that was capped can be admitted in the next cycle.
- R11: While `dq_valid` is high and `dq_ready` is low, `dq_valid` stays high and no entry is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 2 | Per-thread micro-op valid, bit t for thread t |
| in_ready | output | 2 | Per-thread admit, at most one bit set |
| in_src1 | input | 2x6 | Per-thread first source tag |
| in_src1_rdy | input | 2 | Per-thread first source ready |
| in_src2 | input | 2x6 | Per-thread second source tag |
| in_src2_rdy | input | 2 | Per-thread second source ready |
| in_dst | input | 2x6 | Per-thread destination tag |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | 6 | Result broadcast tag |
| dq_valid | output | 1 | Dispatch offer valid |
| dq_ready | input | 1 | Execution unit accepts the offer |
| dq_tid | output | 1 | Thread of the offered entry |
| dq_src1 | output | 6 | First source tag of the offered entry |
| dq_src2 | output | 6 | Second source tag of the offered entry |
| dq_dst | output | 6 | Destination tag of the offered entry |

## Verification
The checks assume that every admitted micro-op names its own destination tag, and that a broadcast tag never matches a source that is already ready in a way that matters. They also assume that an input stream does not drop or change a pending micro-op before it is admitted. The stimulus keeps pending micro-ops steady until their `in_ready` pulse. It uses distinct destination tags, and it broadcasts only tags that waiting entries actually depend on. Because of this, occupancy, counts and age order stay consistent with what the properties expect.

// File: rtl/smt_sched_pkg.sv
package smt_sched_pkg;
  localparam int TAGW = 6;

  typedef struct packed {
    logic            tid;
    logic [TAGW-1:0] s1;
    logic            r1;
    logic [TAGW-1:0] s2;
    logic            r2;
    logic [TAGW-1:0] dst;
  } slot_t;
endpackage

// File: rtl/smt_ins_arb.sv
module smt_ins_arb #(
  parameter int CAP  = 5,
  parameter int CNTW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           in_valid,
  input  logic [1:0][CNTW-1:0] cnt,
  input  logic                 has_free,
  output logic [1:0]           grant
);
  logic       last_q;
  logic       pref;
  logic [1:0] can;

  assign pref = ~last_q;

  for (genvar t = 0; t < 2; t++) begin : g_can
    assign can[t] = in_valid[t] && (cnt[t] < CNTW'(CAP)) && has_free;
  end

  always_comb begin
    grant = '0;
    if (can[pref])       grant[pref]  = 1'b1;
    else if (can[~pref]) grant[~pref] = 1'b1;
  end

  // last admitted thread; reset value makes thread 0 preferred
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= 1'b1;
    else if (|grant) last_q <= grant[1];
  end

  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (can == 2'b11 && $past(|grant)) |-> (grant != $past(grant)));
endmodule

// File: rtl/smt_age_pick.sv
module smt_age_pick #(
  parameter int DEPTH = 8,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins,
  input  logic [IDXW-1:0]  ins_idx,
  input  logic [DEPTH-1:0] elig,
  output logic             any,
  output logic [IDXW-1:0]  pick_idx
);
  // ovr[i][j] set: entry i was admitted before entry j
  logic [DEPTH-1:0][DEPTH-1:0] ovr;
  logic [DEPTH-1:0]            win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= '0;
    end else if (ins) begin
      for (int j = 0; j < DEPTH; j++) begin
        ovr[ins_idx][j] <= 1'b0;
        if (IDXW'(j) != ins_idx) ovr[j][ins_idx] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    logic [DEPTH-1:0] older_col;
    for (genvar j = 0; j < DEPTH; j++) begin : g_col
      assign older_col[j] = (i != j) && ovr[j][i];
    end
    assign win[i] = elig[i] && !(|(elig & older_col));
  end

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (win[i]) pick_idx = IDXW'(i);
  end

  assign any = |elig;

  p_one_oldest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (elig != '0) |-> ($countones(win) == 1));
endmodule

// File: rtl/smt_sched.sv
module smt_sched
  import smt_sched_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CAP   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           in_valid,
  output logic [1:0]           in_ready,
  input  logic [1:0][TAGW-1:0] in_src1,
  input  logic [1:0]           in_src1_rdy,
  input  logic [1:0][TAGW-1:0] in_src2,
  input  logic [1:0]           in_src2_rdy,
  input  logic [1:0][TAGW-1:0] in_dst,
  input  logic                 wb_valid,
  input  logic [TAGW-1:0]      wb_tag,
  output logic                 dq_valid,
  input  logic                 dq_ready,
  output logic                 dq_tid,
  output logic [TAGW-1:0]      dq_src1,
  output logic [TAGW-1:0]      dq_src2,
  output logic [TAGW-1:0]      dq_dst
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  slot_t                 ent [DEPTH];
  logic [DEPTH-1:0]      vld_q;
  logic [1:0][CNTW-1:0]  cnt_q;
  logic [IDXW-1:0]       free_idx;
  logic [IDXW-1:0]       pick_idx;
  logic [DEPTH-1:0]      elig;
  logic [1:0]            grant;
  logic                  has_free, ins, gt, fire, any;
  slot_t                 new_e;

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IDXW'(i);
  end
  assign has_free = ~&vld_q;

  smt_ins_arb #(.CAP(CAP), .CNTW(CNTW)) u_arb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt(cnt_q),
    .has_free(has_free), .grant(grant)
  );

  assign in_ready = grant;
  assign ins      = |grant;
  assign gt       = grant[1];

  // incoming micro-op with same-cycle broadcast bypass
  always_comb begin
    new_e.tid = gt;
    new_e.s1  = in_src1[gt];
    new_e.s2  = in_src2[gt];
    new_e.dst = in_dst[gt];
    new_e.r1  = in_src1_rdy[gt] || (wb_valid && wb_tag == in_src1[gt]);
    new_e.r2  = in_src2_rdy[gt] || (wb_valid && wb_tag == in_src2[gt]);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_elig
    assign elig[i] = vld_q[i] && ent[i].r1 && ent[i].r2;
  end

  smt_age_pick #(.DEPTH(DEPTH), .IDXW(IDXW)) u_age (
    .clk(clk), .rst_n(rst_n), .ins(ins), .ins_idx(free_idx),
    .elig(elig), .any(any), .pick_idx(pick_idx)
  );

  assign dq_valid = any;
  assign dq_tid   = ent[pick_idx].tid;
  assign dq_src1  = ent[pick_idx].s1;
  assign dq_src2  = ent[pick_idx].s2;
  assign dq_dst   = ent[pick_idx].dst;
  assign fire     = dq_valid && dq_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins && free_idx == IDXW'(i)) begin
          vld_q[i] <= 1'b1;
          ent[i]   <= new_e;
        end else begin
          if (fire && pick_idx == IDXW'(i)) vld_q[i] <= 1'b0;
          if (wb_valid && wb_tag == ent[i].s1) ent[i].r1 <= 1'b1;
          if (wb_valid && wb_tag == ent[i].s2) ent[i].r2 <= 1'b1;
        end
      end
    end
  end

  for (genvar t = 0; t < 2; t++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[t] <= '0;
      else cnt_q[t] <= cnt_q[t] + CNTW'(grant[t]) - CNTW'(fire && dq_tid == 1'(t));
    end

    p_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[t] <= CNTW'(CAP));
  end

  p_occ_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == (32'(cnt_q[0]) + 32'(cnt_q[1])));

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&vld_q) |-> (in_ready == 2'b00));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid && !dq_ready) |=> dq_valid);

  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins && wb_valid && wb_tag == in_src1[gt]) |=> ent[$past(free_idx)].r1);

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid |-> (vld_q[pick_idx] && ent[pick_idx].r1 && ent[pick_idx].r2));
endmodule

// File: tb/smt_sched_bench.sv
module smt_sched_bench;
  import smt_sched_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]           in_valid = '0;
  logic [1:0]           in_ready;
  logic [1:0][TAGW-1:0] in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [1:0]           in_src1_rdy = '0, in_src2_rdy = '0;
  logic                 wb_valid = 1'b0;
  logic [TAGW-1:0]      wb_tag = '0;
  logic                 dq_valid, dq_ready = 1'b0, dq_tid;
  logic [TAGW-1:0]      dq_src1, dq_src2, dq_dst;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smt_sched u_smt_sched (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src1(in_src1), .in_src1_rdy(in_src1_rdy), .in_src2(in_src2),
    .in_src2_rdy(in_src2_rdy), .in_dst(in_dst), .wb_valid(wb_valid),
    .wb_tag(wb_tag), .dq_valid(dq_valid), .dq_ready(dq_ready),
    .dq_tid(dq_tid), .dq_src1(dq_src1), .dq_src2(dq_src2), .dq_dst(dq_dst)
  );

  // {iv[2], rdy[2], stag[6], d0[6], d1[6], wbv, wbt[6], dqr, exp_ready[2], exp_dv, exp_dst[6]}
  localparam logic [38:0] VEC [NV] = '{
    {2'b11, 2'b00, 6'd10, 6'd1, 6'd2, 1'b0, 6'd0,  1'b1, 2'b01, 1'b0, 6'd0},
    {2'b11, 2'b00, 6'd10, 6'd3, 6'd2, 1'b0, 6'd0,  1'b1, 2'b10, 1'b0, 6'd0},
    {2'b11, 2'b11, 6'd10, 6'd3, 6'd4, 1'b0, 6'd0,  1'b1, 2'b01, 1'b0, 6'd0},
    {2'b10, 2'b11, 6'd10, 6'd3, 6'd4, 1'b0, 6'd0,  1'b0, 2'b10, 1'b1, 6'd3},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b1, 6'd10, 1'b0, 2'b00, 1'b1, 6'd3},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b1, 6'd1},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b1, 6'd2},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b1, 6'd3},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b1, 6'd4},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b0, 6'd0},
    {2'b01, 2'b00, 6'd12, 6'd5, 6'd0, 1'b1, 6'd12, 1'b1, 2'b01, 1'b0, 6'd0},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b1, 6'd5},
    {2'b00, 2'b00, 6'd0,  6'd0, 6'd0, 1'b0, 6'd0,  1'b1, 2'b00, 1'b0, 6'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus after the falling edge, settle before checks
  task automatic drive(input logic [1:0] iv, input logic [1:0] rdy,
                       input logic [TAGW-1:0] st0, input logic [TAGW-1:0] st1,
                       input logic [TAGW-1:0] d0, input logic [TAGW-1:0] d1,
                       input logic wbv, input logic [TAGW-1:0] wbt, input logic dqr);
    @(negedge clk);
    in_valid    = iv;
    in_src1[0]  = st0;  in_src2[0] = st0;  in_dst[0] = d0;
    in_src1[1]  = st1;  in_src2[1] = st1;  in_dst[1] = d1;
    in_src1_rdy = rdy;  in_src2_rdy = rdy;
    wb_valid    = wbv;  wb_tag = wbt;  dq_ready = dqr;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    drive(2'b00, 2'b00, 0, 0, 0, 0, 1'b0, 0, 1'b1);
    chk("R1 dq_valid", 32'(dq_valid), 0);
    chk("R1 in_ready", 32'(in_ready), 0);

    // table: R1 first admit thread0, R2 alternation, R6 wakeup, R7 bypass,
    // R8 readiness gate, R9 age order, R11 stall hold
    for (int k = 0; k < NV; k++) begin
      logic [38:0] v;
      v = VEC[k];
      drive(v[38:37], v[36:35], v[34:29], v[34:29], v[28:23], v[22:17],
            v[16], v[15:10], v[9]);
      chk("R2 in_ready", 32'(in_ready), 32'(v[8:7]));
      chk("R9 dq_valid", 32'(dq_valid), 32'(v[6]));
      if (v[6]) chk("R9 dq_dst", 32'(dq_dst), 32'(v[5:0]));
    end

    // R3: thread1 preferred but idle, thread0 fills to its cap
    for (int k = 0; k < 5; k++) begin
      drive(2'b01, 2'b00, 20, 21, TAGW'(10 + k), 0, 1'b0, 0, 1'b0);
      chk("R3 idle fallback", 32'(in_ready), 32'(2'b01));
    end
    // R3/R4: thread0 capped, thread1 admitted in consecutive cycles
    for (int k = 0; k < 3; k++) begin
      drive(2'b11, 2'b00, 20, 21, 30, TAGW'(40 + k), 1'b0, 0, 1'b0);
      chk("R4 capped thread skipped", 32'(in_ready), 32'(2'b10));
    end
    // R5: full buffer, thread1 below cap still refused; R8 nothing ready
    drive(2'b11, 2'b00, 20, 21, 30, 44, 1'b0, 0, 1'b0);
    chk("R5 full", 32'(in_ready), 0);
    chk("R8 none ready", 32'(dq_valid), 0);
    // R4: wake thread0 entries, still capped this cycle
    drive(2'b01, 2'b00, 20, 21, 30, 0, 1'b1, 20, 1'b0);
    chk("R4 capped", 32'(in_ready), 0);
    chk("R6 not yet", 32'(dq_valid), 0);
    // R6/R9: oldest woken entry offered; R10 count not yet lowered
    drive(2'b01, 2'b00, 20, 21, 30, 0, 1'b0, 0, 1'b1);
    chk("R6 woken", 32'(dq_valid), 1);
    chk("R9 oldest dst", 32'(dq_dst), 10);
    chk("R9 tid", 32'(dq_tid), 0);
    chk("R10 before edge", 32'(in_ready), 0);
    // R10: freed slot and lowered count admit thread0 next cycle
    drive(2'b01, 2'b00, 20, 21, 30, 0, 1'b0, 0, 1'b0);
    chk("R10 admit after free", 32'(in_ready), 32'(2'b01));
    chk("R9 next oldest", 32'(dq_dst), 11);
    // R11: stalled offer stays
    drive(2'b00, 2'b00, 0, 0, 0, 0, 1'b0, 0, 1'b0);
    chk("R11 hold", 32'(dq_valid), 1);
    chk("R11 same entry", 32'(dq_dst), 11);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule